// File: doc/BRIEF.md
# Program Memory Source Selector

This block decides, one access at a time, whether a program-memory read is served by the on-chip 16 KB code ROM or by the external memory bus. Two kinds of access reach it: instruction fetches, addressed by the program counter, and table reads, which load program code as data. The external-access pin is captured while reset is held and fixes, for the whole run, whether the low part of the code space is on chip or external.

A code-protection rule sits on top of the address split. When the security input is set, a table read issued by code that was itself fetched from external memory may not see internal ROM contents. Such a read reaches neither the ROM nor the bus. The block raises a blocked flag for that access and forces the returned data to 0x00. All route decisions are registered, so the selects appear one clock after the request.

Top module: `pmem_src_sel`

## Requirements
- R1: On every rising clock edge with `rst` high, `ext_pin` is captured. After `rst` falls, changes on `ext_pin` have no effect on routing until the next reset.
- R2: With the captured pin value high, an instruction fetch whose `fetch_pc` is below 16384 gives `rom_sel`=1. A fetch at 16384 or above gives `ext_req`=1.
- R3: With the captured pin value low, every instruction fetch gives `ext_req`=1, and `rom_sel` stays 0.
- R4: A table read (`tbl_valid`=1) issued with `exec_ext`=0 follows the same split as a fetch, using `tbl_addr`. When `tbl_valid` and `fetch_valid` are both high in one cycle, the table read is the one routed.
- R5: With `secure_en`=1, a table read issued with `exec_ext`=1 that would map to the internal ROM produces `tbl_blocked`=1, `rom_sel`=0 and `ext_req`=0. The flag is high for exactly the one cycle that belongs to that request.
- R6: While `tbl_blocked` is 1, `rd_data` is 0x00. In every other cycle `rd_data` equals `rom_rdata`.
- R7: With `secure_en`=0, a table read issued with `exec_ext`=1 follows the normal split. It reaches the ROM only when the captured pin value is high and `tbl_addr` is below 16384.
- R8: With `secure_en`=1, a table read issued with `exec_ext`=1 whose address is 16384 or above, or that is issued while the captured pin value is low, is routed to `ext_req` and is not blocked.
- R9: Outputs respond one clock after the request. A cycle with neither `fetch_valid` nor `tbl_valid` leaves all three outputs 0 on the next clock. All three outputs are 0 after any clock edge with `rst` high.
- R10: At most one of `rom_sel`, `ext_req` and `tbl_blocked` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the external-access pin is captured while high |
| ext_pin | input | 1 | External-access pin; high selects the on-chip ROM for the low code space |
| fetch_valid | input | 1 | Instruction fetch requested this cycle |
| fetch_pc | input | 16 | Program counter of the fetch |
| tbl_valid | input | 1 | Table read (code read as data) requested this cycle |
| tbl_addr | input | 16 | Address of the table read |
| exec_ext | input | 1 | The instruction issuing the table read was fetched from external memory |
| secure_en | input | 1 | Code-protection setting |
| rom_rdata | input | 8 | Data returned by the ROM array |
| rom_sel | output | 1 | Access is served by the internal ROM (registered) |
| ext_req | output | 1 | Access is served by the external bus (registered) |
| tbl_blocked | output | 1 | Table read refused by the protection rule (registered) |
| rd_data | output | 8 | ROM data, forced to 0x00 for a blocked read |

## Verification
The assertions take for granted that reset is high on the first clock edge, so that the captured pin has a defined value before any check runs. They also assume `exec_ext` and `secure_en` are only meaningful alongside `tbl_valid`. The stimulus therefore opens every run with several reset cycles. It then mixes fetches, table reads and cycles carrying both, with addresses clustered at 16383 and 16384. Later phases reset the block again with the pin at the other level, and they keep toggling `ext_pin` after reset to show it is ignored.

// File: rtl/pmem_pkg.sv
package pmem_pkg;

    typedef enum logic [1:0] {
        ROUTE_NONE  = 2'd0,
        ROUTE_ROM   = 2'd1,
        ROUTE_EXT   = 2'd2,
        ROUTE_BLOCK = 2'd3
    } route_e;

    typedef struct packed {
        logic rom;
        logic ext;
        logic blk;
    } route_sel_t;

    function automatic route_sel_t route_expand(input route_e r);
        route_sel_t s;
        s.rom = (r == ROUTE_ROM);
        s.ext = (r == ROUTE_EXT);
        s.blk = (r == ROUTE_BLOCK);
        return s;
    endfunction

endpackage

// File: rtl/pmem_ea_latch.sv
module pmem_ea_latch (
    input  logic clk,
    input  logic rst,
    input  logic ext_pin,
    output logic ea_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ea_q <= ext_pin;
        end
    end

    AST_EA_HELD: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(ea_q)); // R1

endmodule

// File: rtl/pmem_route_decode.sv
module pmem_route_decode
    import pmem_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int ROM_BYTES = 16384
) (
    input  logic              ea_q,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              tbl_valid,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic              exec_ext,
    input  logic              secure_en,
    output route_e            route
);

    logic [ADDR_W-1:0] acc_addr;
    logic              addr_low;
    logic              maps_rom;
    logic              guarded;

    // A table read owns the port when both kinds arrive together
    assign acc_addr = tbl_valid ? tbl_addr : fetch_pc;

    generate
        if (ROM_BYTES >= (2 ** ADDR_W)) begin : g_rom_full
            assign addr_low = 1'b1;
        end else begin : g_rom_part
            localparam logic [ADDR_W:0] ROM_LIM = ROM_BYTES[ADDR_W:0];
            assign addr_low = ({1'b0, acc_addr} < ROM_LIM);
        end
    endgenerate

    assign maps_rom = ea_q && addr_low;
    assign guarded  = tbl_valid && exec_ext && secure_en;

    always_comb begin
        if (!fetch_valid && !tbl_valid) begin
            route = ROUTE_NONE;
        end else if (maps_rom && guarded) begin
            route = ROUTE_BLOCK;
        end else if (maps_rom) begin
            route = ROUTE_ROM;
        end else begin
            route = ROUTE_EXT;
        end
    end

endmodule

// File: rtl/pmem_src_sel.sv
module pmem_src_sel
    import pmem_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int ROM_BYTES = 16384
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_pin,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              tbl_valid,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic              exec_ext,
    input  logic              secure_en,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic              rom_sel,
    output logic              ext_req,
    output logic              tbl_blocked,
    output logic [DATA_W-1:0] rd_data
);

    logic       ea_q;
    route_e     route_d;
    route_sel_t sel_q;

    pmem_ea_latch i_ea_latch (
        .clk     (clk),
        .rst     (rst),
        .ext_pin (ext_pin),
        .ea_q    (ea_q)
    );

    pmem_route_decode #(
        .ADDR_W    (ADDR_W),
        .ROM_BYTES (ROM_BYTES)
    ) i_route_decode (
        .ea_q        (ea_q),
        .fetch_valid (fetch_valid),
        .fetch_pc    (fetch_pc),
        .tbl_valid   (tbl_valid),
        .tbl_addr    (tbl_addr),
        .exec_ext    (exec_ext),
        .secure_en   (secure_en),
        .route       (route_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else begin
            sel_q <= route_expand(route_d);
        end
    end

    assign rom_sel     = sel_q.rom;
    assign ext_req     = sel_q.ext;
    assign tbl_blocked = sel_q.blk;
    assign rd_data     = sel_q.blk ? '0 : rom_rdata;

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rom_sel, ext_req, tbl_blocked})); // R10

    AST_LOW_NO_ROM: assert property (@(posedge clk) disable iff (rst)
        !ea_q |-> !rom_sel); // R3

    AST_HIGH_ADDR_OFFCHIP: assert property (@(posedge clk) disable iff (rst)
        $past(fetch_valid && !tbl_valid && (int'(fetch_pc) >= ROM_BYTES)) |-> !rom_sel); // R2

    AST_BLOCK_CAUSE: assert property (@(posedge clk) disable iff (rst)
        tbl_blocked |-> $past(tbl_valid && exec_ext && secure_en)); // R5

    AST_BLOCK_ZERO: assert property (@(posedge clk) disable iff (rst)
        tbl_blocked |-> (rd_data == '0)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(!fetch_valid && !tbl_valid) |-> !(rom_sel || ext_req || tbl_blocked)); // R9

endmodule

// File: tb/test_pmem_src_sel.sv
`timescale 1ns/1ps
module test_pmem_src_sel;

    localparam int LIM = 16384;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_pin = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [15:0] fetch_pc = '0;
    logic        tbl_valid = 1'b0;
    logic [15:0] tbl_addr = '0;
    logic        exec_ext = 1'b0;
    logic        secure_en = 1'b0;
    logic [7:0]  rom_rdata = '0;
    logic        rom_sel, ext_req, tbl_blocked;
    logic [7:0]  rd_data;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 0;
    bit  m_ea = 0;
    bit  e_rom, e_ext, e_blk;
    string tag;

    always #2.5 clk = ~clk;

    pmem_src_sel i_pmem_src_sel (
        .clk(clk), .rst(rst), .ext_pin(ext_pin),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .tbl_valid(tbl_valid), .tbl_addr(tbl_addr),
        .exec_ext(exec_ext), .secure_en(secure_en),
        .rom_rdata(rom_rdata), .rom_sel(rom_sel), .ext_req(ext_req),
        .tbl_blocked(tbl_blocked), .rd_data(rd_data)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pick_addr();
        case ($urandom_range(0, 3))
            0: return 16'd16383;
            1: return 16'd16384;
            2: return 16'($urandom_range(0, 16383));
            default: return 16'($urandom_range(16384, 65535));
        endcase
    endfunction

    task automatic step(input bit r, input bit pin, input bit fv, input logic [15:0] pc,
                        input bit tv, input logic [15:0] ta, input bit xe, input bit sec);
        int  a;
        bit  low;
        rst = r; ext_pin = pin; fetch_valid = fv; fetch_pc = pc;
        tbl_valid = tv; tbl_addr = ta; exec_ext = xe; secure_en = sec;
        rom_rdata = 8'($urandom_range(1, 255));
        e_rom = 0; e_ext = 0; e_blk = 0;
        if (r) begin
            m_ea = pin;
            tag = "R9";
        end else if (!fv && !tv) begin
            tag = "R9";
        end else begin
            a = tv ? int'(ta) : int'(pc);
            low = m_ea && (a < LIM);
            if (tv && xe && sec && low) begin
                e_blk = 1; tag = "R5";
            end else begin
                e_rom = low; e_ext = !low;
                if (tv && xe && sec) tag = "R8";
                else if (tv && xe) tag = "R7";
                else if (tv) tag = "R4";
                else if (pin != m_ea) tag = "R1";
                else if (m_ea) tag = "R2";
                else tag = "R3";
            end
        end
        @(negedge clk);
        chk(tag, "rom_sel", int'(rom_sel), int'(e_rom));
        chk(tag, "ext_req", int'(ext_req), int'(e_ext));
        chk(tag, "tbl_blocked", int'(tbl_blocked), int'(e_blk));
        chk("R6", "rd_data", int'(rd_data), e_blk ? 0 : int'(rom_rdata));
        chk("R10", "select count", int'(rom_sel) + int'(ext_req) + int'(tbl_blocked) > 1, 0);
    endtask

    task automatic run_phase(input bit pin_at_reset, input int n);
        for (int i = 0; i < 3; i++) step(1, pin_at_reset, 1, 16'd5, 0, 16'd0, 0, 0);
        // R1: pin flips after reset, routing keeps the captured value
        step(0, !pin_at_reset, 1, 16'd0, 0, 16'd0, 0, 0);
        // R5: guarded read into low space
        step(0, !pin_at_reset, 0, 16'd0, 1, 16'd16383, 1, 1);
        // R4: both valid, table read wins
        step(0, pin_at_reset, 1, 16'd20000, 1, 16'd100, 0, 1);
        for (int i = 0; i < n; i++) begin
            int kind = $urandom_range(0, 3);
            step(0, 1'($urandom_range(0, 1)),
                 kind != 1, pick_addr(),
                 kind >= 2, pick_addr(),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
    endtask

    initial begin
        @(negedge clk);
        run_phase(1, 400);
        run_phase(0, 400);
        run_phase(1, 400);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule